// File: doc/BRIEF.md
# Low Pin Count Memory Read Target

This block is the peripheral side of a Low Pin Count bus memory read. On each rising edge of the bus clock it samples the active-low framing strobe and the 4-bit multiplexed data lines. When the host opens a memory read, the block gathers a 32-bit address one nibble at a time and checks that address against a configurable window. If the address is inside the window, the block waits out the host half of the turnaround. It then takes the lines, reports ready status, returns one byte and gives the lines back to the host.

The byte comes from a local memory behind a one-shot request port. That memory must answer with a fixed latency of one or two clocks, set by a parameter. The window is an aligned power-of-two region: its base and its size exponent are parameters. The memory is addressed by the offset inside the window.

Top module: `lpc_read_target`

## Requirements
- R1: A cycle opens only if the nibble sampled on the last clock edge with `frame_n` low is 0000. Any other value in that position makes the block ignore the whole cycle, with `lad_oe` staying low.
- R2: The nibble sampled on the first edge with `frame_n` high is the cycle-type code. The cycle is a memory read only if bits 3:2 are 01 and bit 1 is 0. Bit 0 is ignored, so both 0100 and 0101 are reads. Any other code leaves `lad_oe` low and issues no memory request.
- R3: The next eight edges carry the address, high nibble first. Exactly one single-clock `mem_req` pulse is issued in the clock after the last address nibble. During that pulse `mem_addr` holds address bits [WIN_LOG2-1:0].
- R4: An address whose bits [31:WIN_LOG2] differ from those of `WIN_BASE` produces no memory request and leaves `lad_oe` low.
- R5: `lad_oe` stays low through the address clocks and through the host turnaround clock. It rises after the edge that samples the host turnaround nibble, and in that clock `lad_o` is 1111.
- R6: In the clock after the target turnaround, `lad_o` is 0000, which is the ready status.
- R7: The byte follows over two clocks: bits [3:0] first, then bits [7:4].
- R8: After the data the block drives 1111 for one clock. `lad_oe` then falls, so it is high for exactly five consecutive clocks in each read.
- R9: If `frame_n` is low at any clock edge, `lad_oe` is low in the following clock and the block treats that nibble as a possible new start. A new read that begins part-way through another one completes normally.
- R10: While `rst_n` is low, `lad_oe` and `mem_req` are low.
- R11: With `MEM_LAT` set to 1 or 2, the byte read is the one the memory returns `MEM_LAT` clocks after the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| lclk | input | 1 | Bus clock; all fields are sampled and launched on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_n | input | 1 | Active-low cycle framing strobe from the host |
| lad_i | input | 4 | Nibble currently on the multiplexed bus lines |
| lad_o | output | 4 | Nibble the target drives when enabled |
| lad_oe | output | 1 | Output enable for the bus line drivers |
| mem_req | output | 1 | One-clock read request to the local memory |
| mem_addr | output | WIN_LOG2 | Byte offset inside the window |
| mem_data | input | 8 | Byte returned by the local memory after MEM_LAT clocks |

## Verification
The read path is exercised with in-window addresses that carry distinct nibbles in every position, which separates a correct high-first shift from a reversed or misaligned one. Both in-window and out-of-window addresses are used, together with every valid and invalid cycle-type code, to separate window and type decoding from the drive path. Framing with two low clocks, where the leading zero nibble comes either first or last, tells "last nibble counts" apart from "any zero counts". Frame strobes dropped part-way through an address and part-way through the drive window show whether the block releases the lines and restarts cleanly.

// File: rtl/lpc_tgt_pkg.sv
package lpc_tgt_pkg;

    localparam logic [3:0] NIB_START = 4'h0;
    localparam logic [3:0] NIB_READY = 4'h0;
    localparam logic [3:0] NIB_ONES  = 4'hF;
    localparam int         ADDR_NIBS = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FRAMED,
        ST_ADDR,
        ST_HOST_TAR,
        ST_TGT_TAR,
        ST_READY,
        ST_DATA_LO,
        ST_DATA_HI,
        ST_RET_TAR
    } tgt_state_e;

    function automatic logic is_mem_read(input logic [3:0] code);
        return (code[3:2] == 2'b01) && (code[1] == 1'b0);
    endfunction

endpackage

// File: rtl/lpc_win_decode.sv
module lpc_win_decode #(
    parameter logic [31:0] WIN_BASE = 32'hFFFF_0000,
    parameter int          WIN_LOG2 = 16
) (
    input  logic [31:0]         addr,
    output logic                hit,
    output logic [WIN_LOG2-1:0] offset
);
    localparam int TAG_W = 32 - WIN_LOG2;
    localparam logic [TAG_W-1:0] BASE_TAG = WIN_BASE[31:WIN_LOG2];

    always_comb begin
        hit    = (addr[31:WIN_LOG2] == BASE_TAG);
        offset = addr[WIN_LOG2-1:0];
    end
endmodule

// File: rtl/lpc_mem_lat.sv
module lpc_mem_lat #(
    parameter int LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic cap
);
    generate
        if (LAT <= 1) begin : g_one
            logic stage_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q <= 1'b0;
                else        stage_q <= req;
            end
            assign cap = stage_q;
        end else begin : g_multi
            logic [LAT-1:0] pipe_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q <= '0;
                else        pipe_q <= {pipe_q[LAT-2:0], req};
            end
            assign cap = pipe_q[LAT-1];
        end
    endgenerate
endmodule

// File: rtl/lpc_read_target.sv
module lpc_read_target
    import lpc_tgt_pkg::*;
#(
    parameter logic [31:0] WIN_BASE = 32'hFFFF_0000,
    parameter int          WIN_LOG2 = 16,
    parameter int          MEM_LAT  = 2
) (
    input  logic                lclk,
    input  logic                rst_n,
    input  logic                frame_n,
    input  logic [3:0]          lad_i,
    output logic [3:0]          lad_o,
    output logic                lad_oe,
    output logic                mem_req,
    output logic [WIN_LOG2-1:0] mem_addr,
    input  logic [7:0]          mem_data
);
    localparam int CNT_W = $clog2(ADDR_NIBS);
    localparam int SH_W  = 32 - 4;

    typedef struct packed {
        tgt_state_e          st;
        logic                start_ok;
        logic [CNT_W-1:0]    cnt;
        logic [SH_W-1:0]     sh;
        logic                req;
        logic [WIN_LOG2-1:0] maddr;
        logic [7:0]          data;
        logic [3:0]          drv;
        logic                oe;
    } tgt_regs_t;

    tgt_regs_t cur_q, nxt_d;

    logic [31:0]         full_addr;
    logic                win_hit;
    logic [WIN_LOG2-1:0] win_off;
    logic                data_cap;

    assign full_addr = {cur_q.sh, lad_i};

    lpc_win_decode #(
        .WIN_BASE (WIN_BASE),
        .WIN_LOG2 (WIN_LOG2)
    ) u_win (
        .addr   (full_addr),
        .hit    (win_hit),
        .offset (win_off)
    );

    lpc_mem_lat #(
        .LAT (MEM_LAT)
    ) u_lat (
        .clk   (lclk),
        .rst_n (rst_n),
        .req   (cur_q.req),
        .cap   (data_cap)
    );

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.req = 1'b0;
        if (data_cap) nxt_d.data = mem_data;

        if (!frame_n) begin
            // framing low: abandon anything in flight, note the candidate start
            nxt_d.st       = ST_FRAMED;
            nxt_d.start_ok = (lad_i == NIB_START);
            nxt_d.oe       = 1'b0;
            nxt_d.drv      = NIB_ONES;
        end else begin
            unique case (cur_q.st)
                ST_IDLE: begin
                    nxt_d.oe = 1'b0;
                end
                ST_FRAMED: begin
                    if (cur_q.start_ok && is_mem_read(lad_i)) begin
                        nxt_d.st  = ST_ADDR;
                        nxt_d.cnt = '0;
                    end else begin
                        nxt_d.st  = ST_IDLE;
                    end
                end
                ST_ADDR: begin
                    nxt_d.sh  = full_addr[SH_W-1:0];
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                    if (cur_q.cnt == CNT_W'(ADDR_NIBS - 1)) begin
                        if (win_hit) begin
                            nxt_d.st    = ST_HOST_TAR;
                            nxt_d.req   = 1'b1;
                            nxt_d.maddr = win_off;
                        end else begin
                            nxt_d.st    = ST_IDLE;
                        end
                    end
                end
                ST_HOST_TAR: begin
                    nxt_d.st  = ST_TGT_TAR;
                    nxt_d.oe  = 1'b1;
                    nxt_d.drv = NIB_ONES;
                end
                ST_TGT_TAR: begin
                    nxt_d.st  = ST_READY;
                    nxt_d.drv = NIB_READY;
                end
                ST_READY: begin
                    nxt_d.st  = ST_DATA_LO;
                    nxt_d.drv = data_cap ? mem_data[3:0] : cur_q.data[3:0];
                end
                ST_DATA_LO: begin
                    nxt_d.st  = ST_DATA_HI;
                    nxt_d.drv = cur_q.data[7:4];
                end
                ST_DATA_HI: begin
                    nxt_d.st  = ST_RET_TAR;
                    nxt_d.drv = NIB_ONES;
                end
                ST_RET_TAR: begin
                    nxt_d.st  = ST_IDLE;
                    nxt_d.oe  = 1'b0;
                end
                default: begin
                    nxt_d.st  = ST_IDLE;
                    nxt_d.oe  = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge lclk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q          <= '0;
            cur_q.st       <= ST_IDLE;
            cur_q.drv      <= NIB_ONES;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign lad_o    = cur_q.drv;
    assign lad_oe   = cur_q.oe;
    assign mem_req  = cur_q.req;
    assign mem_addr = cur_q.maddr;

endmodule

// File: rtl/lpc_read_target_chk.sv
module lpc_read_target_chk (
    input logic       lclk,
    input logic       rst_n,
    input logic       frame_n,
    input logic [3:0] lad_o,
    input logic       lad_oe,
    input logic       mem_req
);
    logic [2:0] run_q;

    always_ff @(posedge lclk or negedge rst_n) begin
        if (!rst_n)      run_q <= '0;
        else if (lad_oe) run_q <= (run_q == 3'd7) ? run_q : run_q + 3'd1;
        else             run_q <= '0;
    end

    // R9
    abort_release_chk: assert property (@(posedge lclk) disable iff (!rst_n)
        !frame_n |=> !lad_oe);

    // R5
    tar_ones_chk: assert property (@(posedge lclk) disable iff (!rst_n)
        $rose(lad_oe) |-> lad_o == 4'hF);

    // R6
    ready_follows_chk: assert property (@(posedge lclk) disable iff (!rst_n)
        ($rose(lad_oe) && frame_n) |=> (lad_oe && lad_o == 4'h0));

    // R3
    req_single_chk: assert property (@(posedge lclk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R4
    drive_needs_req_chk: assert property (@(posedge lclk) disable iff (!rst_n)
        $rose(lad_oe) |-> $past(mem_req));

    // R8
    drive_len_chk: assert property (@(posedge lclk) disable iff (!rst_n)
        lad_oe |-> run_q < 3'd5);

    // R10
    reset_quiet_chk: assert property (@(posedge lclk)
        !rst_n |=> (!lad_oe && !mem_req));

endmodule

bind lpc_read_target lpc_read_target_chk u_chk (
    .lclk    (lclk),
    .rst_n   (rst_n),
    .frame_n (frame_n),
    .lad_o   (lad_o),
    .lad_oe  (lad_oe),
    .mem_req (mem_req)
);

// File: tb/lpc_read_target_test.sv
`timescale 1ns/1ps
module lpc_read_target_test;
    localparam int          LAT  = 2;
    localparam int          WL   = 16;
    localparam logic [31:0] BASE = 32'hFFFF_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_n = 1'b1;
    logic [3:0]    lad_i = 4'hF;
    logic [3:0]    lad_o;
    logic          lad_oe;
    logic          mem_req;
    logic [WL-1:0] mem_addr;
    logic [7:0]    mem_data;

    int n_chk = 0;
    int n_bad = 0;
    int n_req = 0;
    logic [WL-1:0] last_addr = '0;
    logic [7:0] m0 = 8'h00, m1 = 8'h00;
    bit done = 1'b0;

    always #2 clk = ~clk;

    lpc_read_target #(.WIN_BASE(BASE), .WIN_LOG2(WL), .MEM_LAT(LAT)) uut (
        .lclk(clk), .rst_n(rst_n), .frame_n(frame_n), .lad_i(lad_i),
        .lad_o(lad_o), .lad_oe(lad_oe), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_data(mem_data)
    );

    function automatic logic [7:0] mem_byte(input logic [WL-1:0] off);
        return (off[7:0] ^ off[15:8]) + 8'h29;
    endfunction

    // memory model with fixed latency
    always @(posedge clk) begin
        if (mem_req) begin
            m0        <= mem_byte(mem_addr);
            last_addr <= mem_addr;
            n_req     <= n_req + 1;
        end
        m1 <= m0;
    end
    assign mem_data = (LAT == 1) ? m0 : m1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit exp_hit(input logic [31:0] a, input logic [3:0] cyc, input logic [3:0] s_last);
        return (s_last == 4'h0) && (cyc[3:2] == 2'b01) && (cyc[1] == 1'b0) && (a[31:WL] == BASE[31:WL]);
    endfunction

    // one full host cycle; two_start puts s_first before s_last while framed
    task automatic do_read(input logic [31:0] a, input logic [3:0] cyc,
                           input logic [3:0] s_first, input logic [3:0] s_last, input bit two_start);
        bit hit;
        int r0;
        logic [7:0] b;
        hit = exp_hit(a, cyc, s_last);
        b   = mem_byte(a[WL-1:0]);
        @(negedge clk);
        r0 = n_req;
        frame_n = 1'b0;
        lad_i   = two_start ? s_first : s_last;
        if (two_start) begin
            @(negedge clk);
            lad_i = s_last;
        end
        @(negedge clk);
        frame_n = 1'b1;
        lad_i   = cyc;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk(!lad_oe, "R5 oe low during address", lad_oe, 0);
            lad_i = a[31-4*i -: 4];
        end
        @(negedge clk);
        chk(!lad_oe, "R5 oe low in host turnaround", lad_oe, 0);
        lad_i = 4'hF;
        @(negedge clk);
        if (hit) begin
            chk(lad_oe && lad_o == 4'hF, "R5 target turnaround drives ones", {lad_oe, lad_o}, 5'h1F);
            chk(n_req == r0 + 1, "R3 one request", n_req - r0, 1);
            chk(last_addr == a[WL-1:0], "R3 request offset", last_addr, a[WL-1:0]);
            @(negedge clk);
            chk(lad_oe && lad_o == 4'h0, "R6 ready nibble", {lad_oe, lad_o}, 5'h10);
            @(negedge clk);
            chk(lad_oe && lad_o == b[3:0], "R7 R11 low data nibble", {lad_oe, lad_o}, {1'b1, b[3:0]});
            @(negedge clk);
            chk(lad_oe && lad_o == b[7:4], "R7 R11 high data nibble", {lad_oe, lad_o}, {1'b1, b[7:4]});
            @(negedge clk);
            chk(lad_oe && lad_o == 4'hF, "R8 return turnaround ones", {lad_oe, lad_o}, 5'h1F);
            @(negedge clk);
            chk(!lad_oe, "R8 release after five clocks", lad_oe, 0);
        end else begin
            chk(n_req == r0, "R1 R2 R4 no request", n_req - r0, 0);
            for (int i = 0; i < 5; i++) begin
                chk(!lad_oe, "R1 R2 R4 no drive", lad_oe, 0);
                @(negedge clk);
            end
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk(!lad_oe, "R10 oe low in reset", lad_oe, 0);
        chk(!mem_req, "R10 no request in reset", mem_req, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // directed reads
        do_read(32'hFFFF_1234, 4'b0100, 4'h0, 4'h0, 1'b0);
        do_read(32'hFFFF_A5C3, 4'b0101, 4'h0, 4'h0, 1'b0);   // R2 bit0 ignored
        do_read(32'hFFFF_0000, 4'b0100, 4'h0, 4'h0, 1'b0);
        do_read(32'hFFFF_FFFF, 4'b0100, 4'h0, 4'h0, 1'b0);
        do_read(32'hFFFE_1234, 4'b0100, 4'h0, 4'h0, 1'b0);   // R4 miss
        do_read(32'h0000_1234, 4'b0100, 4'h0, 4'h0, 1'b0);   // R4 miss
        do_read(32'hFFFF_1234, 4'b0110, 4'h0, 4'h0, 1'b0);   // R2 write
        do_read(32'hFFFF_1234, 4'b1100, 4'h0, 4'h0, 1'b0);   // R2 other type
        do_read(32'hFFFF_4321, 4'b0100, 4'h3, 4'h0, 1'b1);   // R1 last nibble zero
        do_read(32'hFFFF_4321, 4'b0100, 4'h0, 4'h7, 1'b1);   // R1 last nibble non-zero

        // R9: abort part-way through an address, then a full new read
        @(negedge clk);
        frame_n = 1'b0; lad_i = 4'h0;
        @(negedge clk);
        frame_n = 1'b1; lad_i = 4'b0100;
        repeat (3) begin
            @(negedge clk);
            lad_i = 4'hF;
        end
        do_read(32'hFFFF_8E17, 4'b0100, 4'h0, 4'h0, 1'b0);

        // R9: abort inside the drive window
        @(negedge clk);
        frame_n = 1'b0; lad_i = 4'h0;
        @(negedge clk);
        frame_n = 1'b1; lad_i = 4'b0100;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            lad_i = (i < 4) ? 4'hF : 4'h2;
        end
        @(negedge clk); lad_i = 4'hF;
        @(negedge clk);
        chk(lad_oe, "R9 drive started before abort", lad_oe, 1);
        frame_n = 1'b0; lad_i = 4'h5;
        @(negedge clk);
        chk(!lad_oe, "R9 released on framing", lad_oe, 0);
        frame_n = 1'b1; lad_i = 4'hF;
        repeat (4) begin
            @(negedge clk);
            chk(!lad_oe, "R9 stays released", lad_oe, 0);
        end

        // constrained random mix
        for (int k = 0; k < 40; k++) begin
            logic [31:0] a;
            logic [3:0]  cyc;
            logic [3:0]  sf, sl;
            bit          two;
            a = $urandom();
            if ($urandom_range(9) < 7) a[31:16] = 16'hFFFF;
            cyc = ($urandom_range(9) < 8) ? {3'b010, 1'($urandom_range(1))} : 4'($urandom());
            two = 1'($urandom_range(1));
            sf  = 4'($urandom());
            sl  = ($urandom_range(9) < 8) ? 4'h0 : 4'($urandom());
            do_read(a, cyc, sf, sl, two);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule